// File: doc/BRIEF.md
# Operate Instruction Unit

This block carries out the register-only "operate" instructions of a 12-bit accumulator machine. Every action bit in the instruction word controls one small operation on the accumulator or on the one-bit link (carry) register. Several action bits may be set in one word. They then take effect in a fixed internal order, so that one instruction can, for example, clear, negate, increment and rotate in a single pass.

The words fall into two groups. The first group clears, complements, increments, rotates through the link and swaps the two halves of the accumulator. The second group tests the accumulator sign, accumulator zero and link. One bit chooses whether the tests combine by OR or by inverted AND. The same group can also clear the accumulator, OR in a switch register and request a halt. The unit takes the instruction, the accumulator, the link and the switch register. One clock later it presents the new accumulator and link, a skip request, a halt request and a flag for words it does not execute. The accumulator width and the output register stage are parameters.

Top module: `opr_exec_unit`

## Requirements
- R1: While rst_n is low, acc_o, link_o, skip_o, halt_o and unsup_o are all 0. With OUT_REG=1 each result appears on the outputs at the rising clock edge after the inputs that produced it.
- R2: A word with insn_i[11:9]=3'b111 and insn_i[8]=0 is a first-group word. For it skip_o, halt_o and unsup_o are 0.
- R3: A first-group word with insn_i[7:0]=0 leaves the accumulator and link unchanged. The same holds for a second-group word with insn_i[7:1]=0, and that word also gives skip_o=0.
- R4: In the first group, clears come before complements. Bit [7] clears the accumulator, bit [6] clears the link, bit [5] complements the accumulator and bit [4] complements the link. So [7]+[5] gives all ones, and [6]+[4] gives link 1.
- R5: In the first group, bit [0] increments the accumulator after the complements, so [5]+[0] gives the two's-complement negation. A carry out of the accumulator MSB complements the link.
- R6: In the first group, bit [3] rotates the 13-bit link:accumulator value right by one place and bit [2] rotates it left by one place. Rotation happens after the increment.
- R7: In the first group, bit [1] together with exactly one of [3] or [2] rotates by two places in that direction.
- R8: In the first group, bit [1] with neither rotate bit swaps the upper and lower 6-bit halves of the accumulator and keeps the link. When [3] and [2] are both set, neither rotation nor swap happens.
- R9: Clear accumulator, clear link, increment and rotate left together ([7],[6],[0],[2]) give an accumulator of 2 and a link of 0.
- R10: A second group word has insn_i[8]=1 and insn_i[0]=0. Its tests are [6] accumulator negative (MSB set), [5] accumulator zero and [4] link set. With [3]=0, skip_o is 1 when any selected test is true.
- R11: With [3]=1, skip_o is 1 only when no selected test is true. If no test bit is set, skip_o is 1 unconditionally.
- R12: In the second group the tests see the incoming accumulator and link. After the tests, bit [7] clears the accumulator, then bit [2] ORs sw_i into it. Bit [1] sets halt_o. The link is never changed.
- R13: A word with insn_i[11:9]!=3'b111, or with both insn_i[8] and insn_i[0] set, is not executed. It sets unsup_o=1, keeps the accumulator and link, and gives skip_o=0 and halt_o=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_i | input | 12 | Instruction word, bit 11 most significant |
| acc_i | input | DATA_W | Current accumulator |
| link_i | input | 1 | Current link bit |
| sw_i | input | DATA_W | Switch register value |
| acc_o | output | DATA_W | New accumulator |
| link_o | output | 1 | New link bit |
| skip_o | output | 1 | Skip the next instruction |
| halt_o | output | 1 | Halt request |
| unsup_o | output | 1 | Word not executed by this unit |

## Verification
The bench builds the unit with DATA_W=12 and OUT_REG=1. At that width the half-word swap moves 6-bit halves and the carry out of bit 11 lands in the link, which matches the instruction layout. With the output register present, every result can be compared one edge after it is driven. Directed words pin down the ordering corners: clear then complement, negate then rotate, double rotation, both rotate bits set, and inverted sense with no tests. A long run of pseudo-random operate words and operands then mixes every combination of action bits against the bench model.

// File: rtl/opu_pkg.sv
package opu_pkg;

   localparam int INSN_W     = 12;

   // bit indices inside the instruction word (bit 11 is most significant)
   localparam int B_OPC_LO   = 9;
   localparam int B_GROUP    = 8;
   localparam int B_CLR_ACC  = 7;
   localparam int B_G1_CLL   = 6;
   localparam int B_G1_CMA   = 5;
   localparam int B_G1_CML   = 4;
   localparam int B_G1_ROTR  = 3;
   localparam int B_G1_ROTL  = 2;
   localparam int B_G1_TWICE = 1;
   localparam int B_G1_INC   = 0;
   localparam int B_G2_NEG   = 6;
   localparam int B_G2_ZERO  = 5;
   localparam int B_G2_LINK  = 4;
   localparam int B_G2_INV   = 3;
   localparam int B_G2_OSR   = 2;
   localparam int B_G2_HALT  = 1;
   localparam int B_G2_EXT   = 0;

   localparam logic [2:0] OPC_OPERATE = 3'b111;

   typedef enum logic [1:0] {
      KIND_G1  = 2'd0,
      KIND_G2  = 2'd1,
      KIND_BAD = 2'd2
   } op_kind_e;

   typedef struct packed {
      logic clr_acc;
      logic clr_link;
      logic inv_acc;
      logic inv_link;
      logic rot_r;
      logic rot_l;
      logic twice;
      logic inc;
   } g1_ctl_t;

   typedef struct packed {
      logic clr_acc;
      logic t_neg;
      logic t_zero;
      logic t_link;
      logic invert;
      logic or_sw;
      logic halt;
   } g2_ctl_t;

endpackage

// File: rtl/opu_decode.sv
module opu_decode
   import opu_pkg::*;
(
   input  logic [INSN_W-1:0] insn_i,
   output op_kind_e          kind_o,
   output g1_ctl_t           g1_o,
   output g2_ctl_t           g2_o
);

   logic is_operate;
   logic ext_word;

   assign is_operate = (insn_i[INSN_W-1:B_OPC_LO] == OPC_OPERATE);
   assign ext_word   = insn_i[B_GROUP] & insn_i[B_G2_EXT];

   always_comb begin
      if (!is_operate || ext_word) begin
         kind_o = KIND_BAD;
      end else if (insn_i[B_GROUP]) begin
         kind_o = KIND_G2;
      end else begin
         kind_o = KIND_G1;
      end
   end

   always_comb begin
      g1_o.clr_acc  = insn_i[B_CLR_ACC];
      g1_o.clr_link = insn_i[B_G1_CLL];
      g1_o.inv_acc  = insn_i[B_G1_CMA];
      g1_o.inv_link = insn_i[B_G1_CML];
      g1_o.rot_r    = insn_i[B_G1_ROTR];
      g1_o.rot_l    = insn_i[B_G1_ROTL];
      g1_o.twice    = insn_i[B_G1_TWICE];
      g1_o.inc      = insn_i[B_G1_INC];
   end

   always_comb begin
      g2_o.clr_acc = insn_i[B_CLR_ACC];
      g2_o.t_neg   = insn_i[B_G2_NEG];
      g2_o.t_zero  = insn_i[B_G2_ZERO];
      g2_o.t_link  = insn_i[B_G2_LINK];
      g2_o.invert  = insn_i[B_G2_INV];
      g2_o.or_sw   = insn_i[B_G2_OSR];
      g2_o.halt    = insn_i[B_G2_HALT];
   end

endmodule

// File: rtl/opu_rotate.sv
module opu_rotate #(
   parameter int DATA_W = 12
) (
   input  logic [DATA_W:0] vec_i,   // {link, accumulator}
   input  logic            rot_r,
   input  logic            rot_l,
   input  logic            twice,
   output logic [DATA_W:0] vec_o
);

   localparam int N = DATA_W + 1;
   localparam int H = DATA_W / 2;

   logic [N-1:0] r1, r2, l1, l2, swp;

   for (genvar i = 0; i < N; i++) begin : g_rot
      assign r1[i] = vec_i[(i + 1) % N];
      assign r2[i] = vec_i[(i + 2) % N];
      assign l1[i] = vec_i[(i + N - 1) % N];
      assign l2[i] = vec_i[(i + N - 2) % N];
   end

   for (genvar i = 0; i < DATA_W; i++) begin : g_swap
      assign swp[i] = vec_i[(i + H) % DATA_W];
   end
   assign swp[DATA_W] = vec_i[DATA_W];

   always_comb begin
      unique case ({rot_r, rot_l})
         2'b10:   vec_o = twice ? r2 : r1;
         2'b01:   vec_o = twice ? l2 : l1;
         2'b00:   vec_o = twice ? swp : vec_i;
         default: vec_o = vec_i;
      endcase
   end

endmodule

// File: rtl/opu_group1.sv
module opu_group1
   import opu_pkg::*;
#(
   parameter int DATA_W = 12
) (
   input  g1_ctl_t           ctl_i,
   input  logic [DATA_W-1:0] acc_i,
   input  logic              link_i,
   output logic [DATA_W-1:0] acc_o,
   output logic              link_o
);

   logic [DATA_W-1:0] acc_clr, acc_inv;
   logic              link_clr, link_inv;
   logic [DATA_W:0]   inc_vec;

   // step 1: clears
   assign acc_clr  = ctl_i.clr_acc  ? '0   : acc_i;
   assign link_clr = ctl_i.clr_link ? 1'b0 : link_i;

   // step 2: complements
   assign acc_inv  = ctl_i.inv_acc  ? ~acc_clr  : acc_clr;
   assign link_inv = ctl_i.inv_link ? ~link_clr : link_clr;

   // step 3: increment across link:acc, carry flips link
   assign inc_vec = {link_inv, acc_inv} + (DATA_W + 1)'(ctl_i.inc);

   // step 4: rotate or swap
   opu_rotate #(.DATA_W(DATA_W)) u_rot (
      .vec_i (inc_vec),
      .rot_r (ctl_i.rot_r),
      .rot_l (ctl_i.rot_l),
      .twice (ctl_i.twice),
      .vec_o ({link_o, acc_o})
   );

endmodule

// File: rtl/opu_group2.sv
module opu_group2
   import opu_pkg::*;
#(
   parameter int DATA_W = 12
) (
   input  g2_ctl_t           ctl_i,
   input  logic [DATA_W-1:0] acc_i,
   input  logic              link_i,
   input  logic [DATA_W-1:0] sw_i,
   output logic [DATA_W-1:0] acc_o,
   output logic              link_o,
   output logic              skip_o,
   output logic              halt_o
);

   logic any_true;
   logic [DATA_W-1:0] acc_clr;

   // tests see the incoming state
   assign any_true = (ctl_i.t_neg  & acc_i[DATA_W-1])
                   | (ctl_i.t_zero & (acc_i == '0))
                   | (ctl_i.t_link & link_i);

   assign skip_o  = ctl_i.invert ? ~any_true : any_true;
   assign acc_clr = ctl_i.clr_acc ? '0 : acc_i;
   assign acc_o   = ctl_i.or_sw ? (acc_clr | sw_i) : acc_clr;
   assign link_o  = link_i;
   assign halt_o  = ctl_i.halt;

endmodule

// File: rtl/opr_exec_unit.sv
module opr_exec_unit
   import opu_pkg::*;
#(
   parameter int DATA_W  = 12,
   parameter int OUT_REG = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [11:0]       insn_i,
   input  logic [DATA_W-1:0] acc_i,
   input  logic              link_i,
   input  logic [DATA_W-1:0] sw_i,
   output logic [DATA_W-1:0] acc_o,
   output logic              link_o,
   output logic              skip_o,
   output logic              halt_o,
   output logic              unsup_o
);

   if (DATA_W < 4 || (DATA_W % 2) != 0) begin : g_bad_width
      $error("opr_exec_unit: DATA_W must be even and at least 4");
   end
   if (OUT_REG != 0 && OUT_REG != 1) begin : g_bad_outreg
      $error("opr_exec_unit: OUT_REG must be 0 or 1");
   end

   op_kind_e kind;
   g1_ctl_t  g1_ctl;
   g2_ctl_t  g2_ctl;

   logic [DATA_W-1:0] g1_acc, g2_acc, nxt_acc;
   logic              g1_link, g2_link, g2_skip, g2_halt;
   logic              nxt_link, nxt_skip, nxt_halt, nxt_unsup;

   opu_decode u_dec (
      .insn_i (insn_i),
      .kind_o (kind),
      .g1_o   (g1_ctl),
      .g2_o   (g2_ctl)
   );

   opu_group1 #(.DATA_W(DATA_W)) u_g1 (
      .ctl_i  (g1_ctl),
      .acc_i  (acc_i),
      .link_i (link_i),
      .acc_o  (g1_acc),
      .link_o (g1_link)
   );

   opu_group2 #(.DATA_W(DATA_W)) u_g2 (
      .ctl_i  (g2_ctl),
      .acc_i  (acc_i),
      .link_i (link_i),
      .sw_i   (sw_i),
      .acc_o  (g2_acc),
      .link_o (g2_link),
      .skip_o (g2_skip),
      .halt_o (g2_halt)
   );

   always_comb begin
      unique case (kind)
         KIND_G1: begin
            nxt_acc = g1_acc;  nxt_link = g1_link;
            nxt_skip = 1'b0;   nxt_halt = 1'b0;   nxt_unsup = 1'b0;
         end
         KIND_G2: begin
            nxt_acc = g2_acc;  nxt_link = g2_link;
            nxt_skip = g2_skip; nxt_halt = g2_halt; nxt_unsup = 1'b0;
         end
         default: begin
            nxt_acc = acc_i;   nxt_link = link_i;
            nxt_skip = 1'b0;   nxt_halt = 1'b0;   nxt_unsup = 1'b1;
         end
      endcase
   end

   if (OUT_REG == 1) begin : g_out_reg
      logic armed_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            acc_o   <= '0;
            link_o  <= 1'b0;
            skip_o  <= 1'b0;
            halt_o  <= 1'b0;
            unsup_o <= 1'b0;
            armed_q <= 1'b0;
         end else begin
            acc_o   <= nxt_acc;
            link_o  <= nxt_link;
            skip_o  <= nxt_skip;
            halt_o  <= nxt_halt;
            unsup_o <= nxt_unsup;
            armed_q <= 1'b1;
         end
      end

      AST_G1_NEVER_SKIPS: assert property (@(posedge clk) disable iff (!rst_n)
         (armed_q && $past(kind == KIND_G1)) |-> (!skip_o && !halt_o && !unsup_o)); // R2

      AST_G1_NOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
         (armed_q && $past(kind == KIND_G1 && insn_i[7:0] == 8'd0))
         |-> (acc_o == $past(acc_i) && link_o == $past(link_i))); // R3

      AST_NEGATE: assert property (@(posedge clk) disable iff (!rst_n)
         (armed_q && $past(kind == KIND_G1 && insn_i[7:0] == 8'b0010_0001))
         |-> (acc_o == DATA_W'(~$past(acc_i) + 1'b1))); // R5

      AST_G2_UNCOND_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
         (armed_q && $past(kind == KIND_G2 && insn_i[3] && insn_i[6:4] == 3'd0))
         |-> skip_o); // R11

      AST_G2_LINK_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
         (armed_q && $past(kind == KIND_G2)) |-> (link_o == $past(link_i))); // R12

      AST_UNSUP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
         (armed_q && $past(kind == KIND_BAD))
         |-> (unsup_o && !skip_o && !halt_o
              && acc_o == $past(acc_i) && link_o == $past(link_i))); // R13
   end else begin : g_out_comb
      assign acc_o   = nxt_acc;
      assign link_o  = nxt_link;
      assign skip_o  = nxt_skip;
      assign halt_o  = nxt_halt;
      assign unsup_o = nxt_unsup;
   end

endmodule

// File: tb/opr_exec_unit_test.sv
`timescale 1ns/1ps
module opr_exec_unit_test;

   localparam int DW   = 12;
   localparam int MASK = (1 << DW) - 1;
   localparam int HALF = DW / 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [11:0]   insn_i = '0;
   logic [DW-1:0] acc_i = '0;
   logic          link_i = 1'b0;
   logic [DW-1:0] sw_i = '0;
   logic [DW-1:0] acc_o;
   logic          link_o, skip_o, halt_o, unsup_o;

   int checks = 0;
   int fails  = 0;

   always #2 clk = ~clk;   // 250 MHz

   opr_exec_unit #(.DATA_W(DW), .OUT_REG(1)) uut (
      .clk(clk), .rst_n(rst_n), .insn_i(insn_i), .acc_i(acc_i),
      .link_i(link_i), .sw_i(sw_i), .acc_o(acc_o), .link_o(link_o),
      .skip_o(skip_o), .halt_o(halt_o), .unsup_o(unsup_o)
   );

   // first group: {clr_acc, clr_link, inv_acc, inv_link, rot_r, rot_l, twice, inc}
   function automatic logic [11:0] w1(input logic [7:0] b);
      return {3'b111, 1'b0, b};
   endfunction
   // second group: {clr_acc, neg, zero, link, invert, or_sw, halt}
   function automatic logic [11:0] w2(input logic [6:0] b);
      return {3'b111, 1'b1, b, 1'b0};
   endfunction

   task automatic model(input logic [11:0] w, input int a_in, input int l_in, input int s,
                        output int a, output int l, output int sk, output int ht, output int un);
      int n, nl;
      bit any;
      a = a_in; l = l_in; sk = 0; ht = 0; un = 0;
      if (w[11:9] != 3'b111 || (w[8] && w[0])) begin
         un = 1;
      end else if (!w[8]) begin
         if (w[7]) a = 0;
         if (w[6]) l = 0;
         if (w[5]) a = a ^ MASK;
         if (w[4]) l = l ^ 1;
         if (w[0]) begin
            a = a + 1;
            if (a > MASK) begin a = 0; l = l ^ 1; end
         end
         if (w[3] != w[2]) begin
            n = w[1] ? 2 : 1;
            for (int k = 0; k < n; k++) begin
               if (w[3]) begin
                  nl = a & 1;
                  a  = (a >> 1) | (l << (DW - 1));
               end else begin
                  nl = (a >> (DW - 1)) & 1;
                  a  = ((a << 1) & MASK) | l;
               end
               l = nl;
            end
         end else if (!w[3] && w[1]) begin
            a = ((a & ((1 << HALF) - 1)) << HALF) | (a >> HALF);
         end
      end else begin
         any = (w[6] && ((a >> (DW - 1)) & 1) == 1) || (w[5] && a == 0) || (w[4] && l == 1);
         sk  = w[3] ? int'(!any) : int'(any);
         if (w[7]) a = 0;
         if (w[2]) a = a | s;
         ht = w[1] ? 1 : 0;
      end
   endtask

   task automatic apply(input logic [11:0] w, input int a, input int l, input int s,
                        input string tag);
      int ea, el, es, eh, eu;
      @(negedge clk);
      insn_i = w; acc_i = DW'(a); link_i = l[0]; sw_i = DW'(s);
      model(w, a, l, s, ea, el, es, eh, eu);
      @(posedge clk);
      #1;
      checks++;
      if (int'(acc_o) != ea || int'(link_o) != el || int'(skip_o) != es ||
          int'(halt_o) != eh || int'(unsup_o) != eu) begin
         fails++;
         $display("FAIL %s insn=%o acc_in=%h: got acc=%h l=%0d skp=%0d hlt=%0d un=%0d exp acc=%h l=%0d skp=%0d hlt=%0d un=%0d",
                  tag, w, a[DW-1:0], acc_o, link_o, skip_o, halt_o, unsup_o,
                  ea[DW-1:0], el, es, eh, eu);
      end
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   endtask

   initial begin
      #400000;
      fails++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
   end

   initial begin
      // R1: reset state with busy inputs
      insn_i = w2(7'b0000110); acc_i = 12'hFFF; link_i = 1'b1; sw_i = 12'hFFF;
      repeat (3) @(posedge clk);
      #1;
      checks++;
      if (acc_o != '0 || link_o || skip_o || halt_o || unsup_o) begin
         fails++;
         $display("FAIL R1 reset: got acc=%h l=%0d skp=%0d hlt=%0d un=%0d exp all zero",
                  acc_o, link_o, skip_o, halt_o, unsup_o);
      end
      @(negedge clk);
      rst_n = 1'b1;

      // R2 / R3
      apply(w1(8'b1000_0000), 12'h3C5, 1, 0, "R2 clear acc no skip");
      apply(w1(8'b0000_0000), 12'hA5A, 1, 0, "R3 first group nop");
      apply(w2(7'b0000000), 12'h800, 1, 12'hFFF, "R3 second group nop");
      // R4
      apply(w1(8'b1010_0000), 12'h5A5, 0, 0, "R4 clear then complement acc");
      apply(w1(8'b0101_0000), 12'h000, 1, 0, "R4 clear then complement link");
      // R5
      apply(w1(8'b0010_0001), 5, 0, 0, "R5 negate");
      apply(w1(8'b0000_0001), 12'hFFF, 0, 0, "R5 carry sets link");
      apply(w1(8'b0000_0001), 12'hFFF, 1, 0, "R5 carry clears link");
      // R6
      apply(w1(8'b0000_1000), 12'h001, 0, 0, "R6 rotate right into link");
      apply(w1(8'b0000_0100), 12'h800, 0, 0, "R6 rotate left into link");
      apply(w1(8'b0000_0100), 12'h000, 1, 0, "R6 link into lsb");
      // R7
      apply(w1(8'b0000_1010), 12'h003, 0, 0, "R7 double right");
      apply(w1(8'b0000_0110), 12'hC00, 0, 0, "R7 double left");
      // R8
      apply(w1(8'b0000_0010), 12'hABC, 1, 0, "R8 half swap");
      apply(w1(8'b0000_1100), 12'h123, 1, 0, "R8 both rotates hold");
      apply(w1(8'b0000_1110), 12'h456, 0, 0, "R8 both rotates twice hold");
      // R9
      apply(w1(8'b1100_0101), 12'h777, 1, 0, "R9 clear inc rotate left");
      apply(w1(8'b1100_0111), 12'h777, 1, 0, "R9 clear inc rotate left twice");
      // R10
      apply(w2(7'b0100000), 12'h800, 0, 0, "R10 negative skips");
      apply(w2(7'b0010000), 12'h000, 0, 0, "R10 zero skips");
      apply(w2(7'b0001000), 12'h001, 1, 0, "R10 link skips");
      apply(w2(7'b0111000), 12'h001, 0, 0, "R10 none true no skip");
      // R11
      apply(w2(7'b0000100), 12'h123, 0, 0, "R11 unconditional skip");
      apply(w2(7'b0110100), 12'h001, 1, 0, "R11 inverted none true");
      apply(w2(7'b0110100), 12'h000, 0, 0, "R11 inverted one true");
      // R12
      apply(w2(7'b1010000), 12'h000, 1, 0, "R12 test before clear");
      apply(w2(7'b1010000), 12'h005, 0, 0, "R12 clear after test");
      apply(w2(7'b1000010), 12'h0F0, 1, 12'h30C, "R12 clear then or switch");
      apply(w2(7'b0000011), 12'h0F0, 0, 12'h30C, "R12 or switch and halt");
      // R13
      apply(12'b1111_0000_0001, 12'h9AB, 1, 12'hFFF, "R13 extended word");
      apply(12'b1101_1111_1111, 12'h9AB, 0, 12'hFFF, "R13 other opcode");

      // mixed words
      for (int k = 0; k < 3000; k++) begin
         logic [11:0] w;
         w = 12'($urandom);
         if (k % 8 != 0) w[11:9] = 3'b111;
         if (w[11:9] != 3'b111 || (w[8] && w[0]))
            apply(w, int'($urandom) & MASK, int'($urandom) & 1, int'($urandom) & MASK, "R13 mixed");
         else if (w[8])
            apply(w, int'($urandom) & MASK, int'($urandom) & 1, int'($urandom) & MASK, "R10 mixed");
         else
            apply(w, int'($urandom) & MASK, int'($urandom) & 1, int'($urandom) & MASK, "R2 mixed");
      end

      finish_run();
   end

endmodule